// File: doc/BRIEF.md
# DDR Output Serializer with Output-Enable Path

This block sits between core logic and a group of pads. It drives `PAD_W` pad bits from a wider bus that runs at a lower rate. In its default half-rate DDR mode, the core presents four pad-width words each half-rate cycle on `clk_hr`. A half-rate register captures them. A pair selector then hands two words per full-rate cycle to a both-edge stage on `clk_fr`, which runs at twice the half-rate frequency. The both-edge stage puts one word on the pad after the rising edge and the next word after the falling edge.

Output enable takes a lighter path. It has no both-edge stage. In half-rate mode a half-rate register holds two enable words, and a single-rate register on `clk_fr` chooses one of them per full-rate cycle. The enable is active high and applies per bit. The block also loops the pad back. `rx_o` follows the driven value wherever the pad is enabled, and the external level `pad_i` wherever the pad is released.

The `MODE` parameter selects a smaller variant:
- full-rate DDR, where a two-word bus goes straight into the both-edge stage;
- simple register, where a single-rate register feeds the pad;
- bypass, where the core drives the pad directly.

Every register shares one asynchronous clear, one synchronous clear and one clock enable. The `PRESET` parameter selects whether the clears load zeros or ones.

Top module: `ddr_oe_serializer`

## Requirements
- R1: While `areset` is high, and until the first load after it, every register holds the fill value. The fill value is all `PRESET` bits, default 0. So with the default, `pad_o` = 0, `pad_oe_o` = 0 and `rx_o` = `pad_i`.
- R2: In half-rate DDR mode, a `din` value captured on a `clk_hr` rising edge E reaches the pad one full-rate period after E. Its first word appears on the `clk_fr` rising edge that follows E, not the one that coincides with it. The four words follow in consecutive `clk_fr` half periods.
- R3: The words go out in this order: `din[W-1:0]`, `din[2W-1:W]`, `din[3W-1:2W]`, `din[4W-1:3W]`. Within a word, the LSB drives pad bit 0. In each full-rate cycle, the earlier word of the pair is on the pad while `clk_fr` is high and the later word while it is low.
- R4: In half-rate mode, `oe` is 2W bits. `oe[W-1:0]` sets `pad_oe_o` for the full-rate cycle that carries words 0 and 1. `oe[2W-1:W]` sets it for the cycle that carries words 2 and 3. Bit i governs pad bit i, and 1 means driven.
- R5: For each bit i, `rx_o[i]` equals `pad_o[i]` when `pad_oe_o[i]` is 1, and equals `pad_i[i]` when it is 0.
- R6: While `ce` is low and `sclr` is low, no data or enable register changes. The pad keeps repeating the last loaded word pair and enable, and `din`/`oe` are ignored.
- R7: `sclr` high loads the fill value into every register at the next edge of that register's clock, whatever `ce` is. With the default fill, this gives `pad_o` = 0 and `pad_oe_o` = 0 on both `clk_fr` phases.
- R8: In simple-register mode, `din` and `oe` are W bits wide. Both are registered on the `clk_fr` rising edge and held on the pad for the whole full-rate cycle.
- R9: In bypass mode, `pad_o` equals `din` and `pad_oe_o` equals `oe`, with no clock delay.
- R10: In full-rate DDR mode, `din` is 2W bits wide and is captured on a `clk_fr` rising edge. `din[W-1:0]` is on the pad during the high phase that follows, and `din[2W-1:W]` during the low phase. `oe` (W bits) holds for that cycle.
- R11: The pair selector takes its phase from a toggle in the `clk_hr` domain and not from reset timing. The first pair is never chosen on two consecutive `clk_fr` rising edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fr | input | 1 | Full-rate clock for the both-edge stage and the single-rate enable register |
| clk_hr | input | 1 | Half-rate clock, edge-aligned with `clk_fr` at half its frequency |
| areset | input | 1 | Asynchronous clear, active high, loads the fill value |
| sclr | input | 1 | Synchronous clear, active high, loads the fill value |
| ce | input | 1 | Clock enable for all data and enable registers |
| din | input | DIN_W | Core data: 4×PAD_W, 2×PAD_W or PAD_W bits depending on MODE |
| oe | input | OE_W | Core output enable: 2×PAD_W bits in half-rate mode, PAD_W bits otherwise |
| pad_i | input | PAD_W | Level seen on the pad from outside |
| pad_o | output | PAD_W | Value driven toward the pad |
| pad_oe_o | output | PAD_W | Per-bit pad drive enable, active high |
| rx_o | output | PAD_W | Pad level returned to the input side |

## Verification
The half-rate stream is exercised with several bus values:
- Distinct nibble ramps (`3210`, `FEDC`) show whether word order and pair placement within the full-rate cycle are correct. A swap of the pair or of the halves gives a visibly different pad sequence.
- All-zero and all-one words, together with mixed enable patterns, separate a per-bit enable from a whole-bus enable. They also show whether the upper enable half reaches the second cycle instead of the first.
- A held `ce` with changed inputs, and a `sclr` pulse while data is streaming, show whether the hold and clear reach both the rising-edge and falling-edge registers.

Each of the three smaller modes gets one direct pattern that tells a registered path from a combinational one.

// File: rtl/dos_pkg.sv
`timescale 1ns/1ps
package dos_pkg;

    typedef enum logic [1:0] {
        MODE_BYPASS = 2'd0,
        MODE_SREG   = 2'd1,
        MODE_DDR_FR = 2'd2,
        MODE_DDR_HR = 2'd3
    } dos_mode_e;

    // pad-width words carried by the core data bus in each mode
    function automatic int din_words(dos_mode_e m);
        case (m)
            MODE_DDR_HR: return 4;
            MODE_DDR_FR: return 2;
            default:     return 1;
        endcase
    endfunction

    // pad-width words carried by the core enable bus in each mode
    function automatic int oe_words(dos_mode_e m);
        return (m == MODE_DDR_HR) ? 2 : 1;
    endfunction

endpackage

// File: rtl/dos_hr_stage.sv
`timescale 1ns/1ps
module dos_hr_stage #(
    parameter int PAD_W  = 4,
    parameter bit PRESET = 1'b0
)(
    input  logic                 clk_hr,
    input  logic                 areset,
    input  logic                 sclr,
    input  logic                 ce,
    input  logic [4*PAD_W-1:0]   din,
    input  logic [2*PAD_W-1:0]   oe_in,
    output logic [4*PAD_W-1:0]   data_o,
    output logic [2*PAD_W-1:0]   oe_o,
    output logic                 tog_o
);
    localparam int DW = 4 * PAD_W;
    localparam int EW = 2 * PAD_W;

    typedef struct packed {
        logic [DW-1:0] data;
        logic [EW-1:0] oe;
        logic          tog;
    } hr_state_t;

    hr_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        // phase marker runs freely so the full-rate side can always lock
        st_d.tog = ~st_q.tog;
        if (sclr) begin
            st_d.data = {DW{PRESET}};
            st_d.oe   = {EW{PRESET}};
        end else if (ce) begin
            st_d.data = din;
            st_d.oe   = oe_in;
        end
    end

    always_ff @(posedge clk_hr or posedge areset) begin
        if (areset) begin
            st_q <= '{data: {DW{PRESET}}, oe: {EW{PRESET}}, tog: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign data_o = st_q.data;
    assign oe_o   = st_q.oe;
    assign tog_o  = st_q.tog;

    // R6
    hr_hold_chk: assert property (@(posedge clk_hr) disable iff (areset)
        (!ce && !sclr) |=> ($stable(st_q.data) && $stable(st_q.oe)));

endmodule

// File: rtl/dos_pair_sel.sv
`timescale 1ns/1ps
module dos_pair_sel #(
    parameter int PAD_W = 4
)(
    input  logic                 clk_fr,
    input  logic                 areset,
    input  logic                 tog_hr,
    input  logic [4*PAD_W-1:0]   hr_data,
    input  logic [2*PAD_W-1:0]   hr_oe,
    output logic [PAD_W-1:0]     lo_o,
    output logic [PAD_W-1:0]     hi_o,
    output logic [PAD_W-1:0]     oe_o
);
    logic tog_d, tog_q;
    logic first;

    always_comb begin
        tog_d = tog_hr;
        // a changed marker means a new half-rate word landed since the last full-rate edge
        first = (tog_hr != tog_q);
        if (first) begin
            lo_o = hr_data[0*PAD_W +: PAD_W];
            hi_o = hr_data[1*PAD_W +: PAD_W];
            oe_o = hr_oe[0 +: PAD_W];
        end else begin
            lo_o = hr_data[2*PAD_W +: PAD_W];
            hi_o = hr_data[3*PAD_W +: PAD_W];
            oe_o = hr_oe[PAD_W +: PAD_W];
        end
    end

    always_ff @(posedge clk_fr or posedge areset) begin
        if (areset) begin
            tog_q <= 1'b0;
        end else begin
            tog_q <= tog_d;
        end
    end

    // R11
    phase_alt_chk: assert property (@(posedge clk_fr) disable iff (areset)
        first |=> !first);

endmodule

// File: rtl/dos_fr_stage.sv
`timescale 1ns/1ps
module dos_fr_stage #(
    parameter int PAD_W  = 4,
    parameter bit DDR    = 1'b1,
    parameter bit PRESET = 1'b0
)(
    input  logic               clk_fr,
    input  logic               areset,
    input  logic               sclr,
    input  logic               ce,
    input  logic [PAD_W-1:0]   lo_in,
    input  logic [PAD_W-1:0]   hi_in,
    input  logic [PAD_W-1:0]   oe_in,
    output logic [PAD_W-1:0]   pad_o,
    output logic [PAD_W-1:0]   oe_o
);
    localparam logic [PAD_W-1:0] FILL = {PAD_W{PRESET}};

    typedef struct packed {
        logic [PAD_W-1:0] lo;
        logic [PAD_W-1:0] hi;
        logic [PAD_W-1:0] oe;
    } fr_state_t;

    fr_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (sclr) begin
            st_d = '{lo: FILL, hi: FILL, oe: FILL};
        end else if (ce) begin
            st_d.lo = lo_in;
            st_d.hi = hi_in;
            st_d.oe = oe_in;
        end
    end

    always_ff @(posedge clk_fr or posedge areset) begin
        if (areset) begin
            st_q <= '{lo: FILL, hi: FILL, oe: FILL};
        end else begin
            st_q <= st_d;
        end
    end

    assign oe_o = st_q.oe;

    generate
        if (DDR) begin : g_ddr
            logic [PAD_W-1:0] fall_d, fall_q;
            // the later word is retimed to the falling edge so it is stable through the low phase
            always_comb fall_d = st_q.hi;
            always_ff @(negedge clk_fr or posedge areset) begin
                if (areset) begin
                    fall_q <= FILL;
                end else begin
                    fall_q <= fall_d;
                end
            end
            assign pad_o = clk_fr ? st_q.lo : fall_q;
        end else begin : g_sdr
            assign pad_o = st_q.lo;
        end
    endgenerate

    // R6
    fr_hold_chk: assert property (@(posedge clk_fr) disable iff (areset)
        (!ce && !sclr) |=> $stable(st_q));

    // R7
    fr_clear_chk: assert property (@(posedge clk_fr) disable iff (areset)
        sclr |=> (st_q.lo == FILL && st_q.hi == FILL && st_q.oe == FILL));

endmodule

// File: rtl/ddr_oe_serializer.sv
`timescale 1ns/1ps
module ddr_oe_serializer
    import dos_pkg::*;
#(
    parameter int        PAD_W  = 4,
    parameter dos_mode_e MODE   = MODE_DDR_HR,
    parameter bit        PRESET = 1'b0,
    localparam int       DIN_W  = PAD_W * din_words(MODE),
    localparam int       OE_W   = PAD_W * oe_words(MODE)
)(
    input  logic               clk_fr,
    input  logic               clk_hr,
    input  logic               areset,
    input  logic               sclr,
    input  logic               ce,
    input  logic [DIN_W-1:0]   din,
    input  logic [OE_W-1:0]    oe,
    input  logic [PAD_W-1:0]   pad_i,
    output logic [PAD_W-1:0]   pad_o,
    output logic [PAD_W-1:0]   pad_oe_o,
    output logic [PAD_W-1:0]   rx_o
);

    generate
        if (MODE == MODE_DDR_HR) begin : g_hr
            logic [4*PAD_W-1:0] hr_data;
            logic [2*PAD_W-1:0] hr_oe;
            logic               hr_tog;
            logic [PAD_W-1:0]   pair_lo, pair_hi, pair_oe;

            dos_hr_stage #(.PAD_W(PAD_W), .PRESET(PRESET)) u_hr (
                .clk_hr (clk_hr),
                .areset (areset),
                .sclr   (sclr),
                .ce     (ce),
                .din    (din),
                .oe_in  (oe),
                .data_o (hr_data),
                .oe_o   (hr_oe),
                .tog_o  (hr_tog)
            );

            dos_pair_sel #(.PAD_W(PAD_W)) u_sel (
                .clk_fr  (clk_fr),
                .areset  (areset),
                .tog_hr  (hr_tog),
                .hr_data (hr_data),
                .hr_oe   (hr_oe),
                .lo_o    (pair_lo),
                .hi_o    (pair_hi),
                .oe_o    (pair_oe)
            );

            dos_fr_stage #(.PAD_W(PAD_W), .DDR(1'b1), .PRESET(PRESET)) u_fr (
                .clk_fr (clk_fr),
                .areset (areset),
                .sclr   (sclr),
                .ce     (ce),
                .lo_in  (pair_lo),
                .hi_in  (pair_hi),
                .oe_in  (pair_oe),
                .pad_o  (pad_o),
                .oe_o   (pad_oe_o)
            );
        end else if (MODE == MODE_DDR_FR) begin : g_fr
            dos_fr_stage #(.PAD_W(PAD_W), .DDR(1'b1), .PRESET(PRESET)) u_fr (
                .clk_fr (clk_fr),
                .areset (areset),
                .sclr   (sclr),
                .ce     (ce),
                .lo_in  (din[PAD_W-1:0]),
                .hi_in  (din[DIN_W-1:PAD_W]),
                .oe_in  (oe),
                .pad_o  (pad_o),
                .oe_o   (pad_oe_o)
            );
        end else if (MODE == MODE_SREG) begin : g_reg
            dos_fr_stage #(.PAD_W(PAD_W), .DDR(1'b0), .PRESET(PRESET)) u_fr (
                .clk_fr (clk_fr),
                .areset (areset),
                .sclr   (sclr),
                .ce     (ce),
                .lo_in  (din),
                .hi_in  (din),
                .oe_in  (oe),
                .pad_o  (pad_o),
                .oe_o   (pad_oe_o)
            );
        end else begin : g_byp
            assign pad_o    = din;
            assign pad_oe_o = oe;
        end
    endgenerate

    // loopback: driven bits return their own value, released bits return the outside level
    assign rx_o = (pad_oe_o & pad_o) | (~pad_oe_o & pad_i);

endmodule

// File: tb/ddr_oe_serializer_tb_top.sv
`timescale 1ns/1ps
module ddr_oe_serializer_tb_top;
    import dos_pkg::*;

    localparam int W = 4;

    logic clk_fr = 1'b0;
    logic clk_hr = 1'b0;
    logic areset = 1'b0;
    logic sclr   = 1'b0;
    logic ce     = 1'b1;
    logic one    = 1'b1;
    logic zero   = 1'b0;
    logic [W-1:0] pad_in = 4'hA;

    // half-rate DDR instance
    logic [4*W-1:0] din_h = '0;
    logic [2*W-1:0] oe_h  = '0;
    logic [W-1:0]   pad_h, poe_h, rx_h;
    // full-rate DDR instance
    logic [2*W-1:0] din_f = '0;
    logic [W-1:0]   oe_f  = '0;
    logic [W-1:0]   pad_f, poe_f, rx_f;
    // simple register instance
    logic [W-1:0]   din_r = '0, oe_r = '0;
    logic [W-1:0]   pad_r, poe_r, rx_r;
    // bypass instance
    logic [W-1:0]   din_b = '0, oe_b = '0;
    logic [W-1:0]   pad_b, poe_b, rx_b;

    ddr_oe_serializer #(.PAD_W(W), .MODE(MODE_DDR_HR)) dut_i (
        .clk_fr(clk_fr), .clk_hr(clk_hr), .areset(areset), .sclr(sclr), .ce(ce),
        .din(din_h), .oe(oe_h), .pad_i(pad_in), .pad_o(pad_h), .pad_oe_o(poe_h), .rx_o(rx_h));

    ddr_oe_serializer #(.PAD_W(W), .MODE(MODE_DDR_FR)) dut_fr_i (
        .clk_fr(clk_fr), .clk_hr(clk_hr), .areset(areset), .sclr(zero), .ce(one),
        .din(din_f), .oe(oe_f), .pad_i(pad_in), .pad_o(pad_f), .pad_oe_o(poe_f), .rx_o(rx_f));

    ddr_oe_serializer #(.PAD_W(W), .MODE(MODE_SREG)) dut_reg_i (
        .clk_fr(clk_fr), .clk_hr(clk_hr), .areset(areset), .sclr(zero), .ce(one),
        .din(din_r), .oe(oe_r), .pad_i(pad_in), .pad_o(pad_r), .pad_oe_o(poe_r), .rx_o(rx_r));

    ddr_oe_serializer #(.PAD_W(W), .MODE(MODE_BYPASS)) dut_byp_i (
        .clk_fr(clk_fr), .clk_hr(clk_hr), .areset(areset), .sclr(zero), .ce(one),
        .din(din_b), .oe(oe_b), .pad_i(pad_in), .pad_o(pad_b), .pad_oe_o(poe_b), .rx_o(rx_b));

    // 125 MHz full-rate clock; half-rate clock toggles on every full-rate rising edge
    initial forever begin
        #4; clk_fr = 1'b1; clk_hr = ~clk_hr;
        #4; clk_fr = 1'b0;
    end

    int checks = 0;
    int fails  = 0;

    typedef struct {
        time          due;
        logic [W-1:0] d;
        logic [W-1:0] e;
    } exp_t;
    exp_t sb[$];

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s at %0t: actual %h expected %h", req, $time, act, exp);
        end
    endtask

    // driver: one half-rate bus word, expected pad words pushed with their due sample times
    task automatic drive_hr(input logic [4*W-1:0] d, input logic [2*W-1:0] e);
        time t0;
        @(posedge clk_hr);
        t0 = $time;
        #2;
        din_h = d;
        oe_h  = e;
        for (int i = 0; i < 4; i++) begin
            exp_t it;
            it.due = t0 + 26 + 4 * i;
            it.d   = d[i*W +: W];
            it.e   = (i < 2) ? e[W-1:0] : e[2*W-1:W];
            sb.push_back(it);
        end
    endtask

    task automatic mon_sample();
        while (sb.size() > 0 && sb[0].due < $time) begin
            exp_t lost;
            lost = sb.pop_front();
            checks++;
            fails++;
            $display("FAIL R2 missed sample due %0t: actual none expected %h", lost.due, lost.d);
        end
        if (sb.size() > 0 && sb[0].due == $time) begin
            exp_t it;
            it = sb.pop_front();
            chk("R2 R3 R11 pad word", pad_h, it.d);
            chk("R4 pad enable", poe_h, it.e);
            chk("R5 loopback", rx_h, (it.e & it.d) | (~it.e & pad_in));
        end
    endtask

    // monitor: sample high phase and low phase of every full-rate cycle
    initial forever begin
        @(posedge clk_fr);
        #2; mon_sample();
        #4; mon_sample();
    end

    task automatic run_all();
        // R1 reset state
        #1 areset = 1'b1;
        #2;
        chk("R1 reset pad", pad_h, 4'h0);
        chk("R1 reset enable", poe_h, 4'h0);
        chk("R1 reset loopback", rx_h, pad_in);
        #38 areset = 1'b0;

        // streaming patterns
        drive_hr(16'h3210, 8'hFF);
        drive_hr(16'hFEDC, 8'hFF);
        drive_hr(16'h0000, 8'hF0);
        drive_hr(16'hFFFF, 8'h5A);
        drive_hr(16'hA5C3, 8'h00);
        drive_hr(16'h7E81, 8'hC3);
        wait (sb.size() == 0);
        repeat (3) @(posedge clk_hr);

        // R6 clock enable low: pad repeats words 2/3 of the last bus word
        @(posedge clk_hr);
        #2;
        ce = 1'b0; din_h = 16'h5555; oe_h = 8'h00;
        for (int k = 0; k < 6; k++) begin
            @(posedge clk_fr);
            #2;
            chk("R6 held high-phase word", pad_h, 4'hE);
            chk("R6 held enable", poe_h, 4'hC);
            #4;
            chk("R6 held low-phase word", pad_h, 4'h7);
        end
        ce = 1'b1; din_h = 16'h9999; oe_h = 8'hFF;
        repeat (3) @(posedge clk_hr);

        // R7 synchronous clear overrides streaming data
        @(posedge clk_hr);
        #2;
        sclr = 1'b1;
        for (int k = 0; k < 3; k++) begin
            @(posedge clk_fr);
            #2;
            chk("R7 cleared high-phase word", pad_h, 4'h0);
            chk("R7 cleared enable", poe_h, 4'h0);
            chk("R7 cleared loopback", rx_h, pad_in);
            #4;
            chk("R7 cleared low-phase word", pad_h, 4'h0);
        end
        @(posedge clk_hr);
        #2 sclr = 1'b0;
        drive_hr(16'h1357, 8'hFF);
        wait (sb.size() == 0);

        // R10 full-rate DDR mode
        @(posedge clk_fr);
        #2; din_f = 8'hB4; oe_f = 4'hF;
        @(posedge clk_fr);
        #2;
        chk("R10 low word on high phase", pad_f, 4'h4);
        chk("R10 enable", poe_f, 4'hF);
        #4;
        chk("R10 high word on low phase", pad_f, 4'hB);
        din_f = 8'h3C; oe_f = 4'h0;
        @(posedge clk_fr);
        #2;
        chk("R10 low word", pad_f, 4'hC);
        chk("R10 released enable", poe_f, 4'h0);
        chk("R10 R5 released loopback", rx_f, pad_in);
        #4;
        chk("R10 high word", pad_f, 4'h3);

        // R8 simple register mode
        @(posedge clk_fr);
        #2; din_r = 4'h6; oe_r = 4'hF;
        #4;
        chk("R8 not yet registered", pad_r, 4'h0);
        @(posedge clk_fr);
        #2;
        chk("R8 registered high phase", pad_r, 4'h6);
        #4;
        chk("R8 registered low phase", pad_r, 4'h6);
        chk("R8 registered enable", poe_r, 4'hF);

        // R9 bypass mode
        din_b = 4'h9; oe_b = 4'h5;
        #1;
        chk("R9 bypass data", pad_b, 4'h9);
        chk("R9 bypass enable", poe_b, 4'h5);
        chk("R9 R5 bypass loopback", rx_b, (4'h5 & 4'h9) | (~4'h5 & pad_in));

        repeat (2) @(posedge clk_fr);
    endtask

    initial begin
        fork
            run_all();
            begin
                #200000;
                checks++;
                fails++;
                $display("FAIL watchdog (all requirements): actual timeout expected completion");
            end
        join_any
        disable fork;
        checks++;
        if (sb.size() != 0) begin
            fails++;
            $display("FAIL R2 scoreboard drain: actual %0d expected 0", sb.size());
        end
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule